// File: doc/BRIEF.md
# Low-Speed Oscillator Failure Monitor

This block watches a slow external oscillator in the 32 kHz class. That oscillator drives a real-time-clock domain and can also be picked as the system clock. The block samples the slow clock with a faster reference clock. It declares a failure when no rising edge of the slow clock arrives within a programmable number of reference cycles.

Software turns the monitor on through an enable write. The write takes effect only when both low-speed oscillators (external and internal) are switched on and ready, and a real-time-clock source is selected. Once the enable is set, software cannot clear it. It drops only on a power-on reset, on a real-time-clock software reset, or when the monitor detects a failure.

When a failure is detected, the block does the following:
- It closes the gate on the clock forwarded to the real-time-clock domain.
- It raises a sticky flag that drives a non-maskable interrupt.
- If the failed clock is the system clock, it switches the system-clock selection to the low-speed internal source.
- In the low-power mode, it requests a wake-up.

A system reset returns the system-clock selection to its default but leaves the monitor running.

Top module: `lsclk_fail_mon`

## Requirements
- R1: A write with `en_wr`=1 and `en_wdata`=1 sets `mon_en` on the next clock, but only if `xosc_on`, `xosc_rdy`, `iosc_on` and `iosc_rdy` are all 1 and `rtc_src` is not 0 (0 means no source). Any other write leaves `mon_en` at 0.
- R2: A write with `en_wdata`=0 does not clear `mon_en`. `mon_en` clears on `por_n`=0, on an `rtc_swrst` pulse, or on a detected failure.
- R3: `sys_rst_n`=0 resets `sysclk_sel` to 0 and leaves `mon_en`, `fail_flag` and the failure detector unchanged. Only `por_n`=0 clears the monitor, and after it every output is 0.
- R4: With `pmode` = 2 (standby) or 3 (shutdown), no failure is detected, even with the slow clock stopped. Encoding: 0 run, 1 low-power, 2 standby, 3 shutdown.
- R5: `rtc_clk_o` follows `lsclk_in` until a failure. After a failure it stays 0 until `por_n` or `rtc_swrst` reopens it.
- R6: On a failure with `sysclk_sel`=3 (external low-speed), `sysclk_sel` becomes 2 (internal low-speed) on the next clock. With any other selection it is left alone. Codes: 0 internal high-speed, 1 external high-speed, 2 internal low-speed, 3 external low-speed.
- R7: A failure while `pmode`=1 sets `wake_req`. `wake_req` clears when `pmode` returns to 0. A failure in run mode does not set it.
- R8: `fail_flag` stays 1 after a failure until `flag_clr` is pulsed.
- R9: A failure is declared only after `win_limit` reference cycles pass with no synchronized rising edge of `lsclk_in` while the monitor is active. Edges arriving faster than that never trip it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, much faster than the monitored clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| sys_rst_n | input | 1 | System reset, synchronous, active low; affects only the system-clock selection |
| rtc_swrst | input | 1 | Real-time-clock software reset pulse; clears the enable and reopens the gate |
| lsclk_in | input | 1 | Monitored external low-speed clock |
| xosc_on | input | 1 | External low-speed oscillator is switched on |
| xosc_rdy | input | 1 | External low-speed oscillator is ready |
| iosc_on | input | 1 | Internal low-speed oscillator is switched on |
| iosc_rdy | input | 1 | Internal low-speed oscillator is ready |
| rtc_src | input | 2 | Real-time-clock source choice; 0 means none |
| pmode | input | 2 | Power mode: 0 run, 1 low-power, 2 standby, 3 shutdown |
| en_wr | input | 1 | Enable write strobe |
| en_wdata | input | 1 | Enable write value |
| flag_clr | input | 1 | Clears the failure flag |
| sel_wr | input | 1 | System-clock selection write strobe |
| sel_wdata | input | 2 | System-clock selection value |
| win_limit | input | CNT_W | Reference cycles allowed without a slow-clock edge |
| mon_en | output | 1 | Monitor enable |
| fail_flag | output | 1 | Sticky failure flag, drives the non-maskable interrupt |
| wake_req | output | 1 | Wake-up request after a failure in low-power mode |
| sysclk_sel | output | 2 | Effective system-clock selection |
| rtc_clk_o | output | 1 | Gated clock to the real-time-clock domain |

## Verification
The enable-write path is tried with a table of eight oscillator and source combinations. Each vector removes exactly one readiness condition or sends a zero write, so every term of the acceptance condition is shown to be needed.

The detector is run against three slow-clock patterns:
- A healthy toggling clock, which must never trip.
- A clock stopped for less than the window, which must not trip.
- A clock stopped for longer than the window, which must trip.

The stopped case is repeated in standby, shutdown, low-power and run modes, which separates the mode gating, the wake-up path and the system-clock override. The gate is observed through `rtc_clk_o` before the failure, after it, and after the reopening reset.

// File: rtl/lsfm_pkg.sv
// Package: shared encodings for the low-speed failure monitor.
// Assumes the 2-bit power-mode and system-clock codes listed in the brief.
package lsfm_pkg;
    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_LOWP  = 2'd1,
        PM_STBY  = 2'd2,
        PM_SHDN  = 2'd3
    } pmode_e;

    typedef enum logic [1:0] {
        SYS_HSI_INT = 2'd0,
        SYS_HS_EXT  = 2'd1,
        SYS_LS_INT  = 2'd2,
        SYS_LS_EXT  = 2'd3
    } sysclk_e;
endpackage

// File: rtl/lsfm_edge_sync.sv
// Module: brings the slow clock into the reference domain and flags its rising edges.
// Assumes the reference clock runs several times faster than the monitored clock.
module lsfm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic async_in,
    output logic rise_o
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    // Shift the slow clock through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!por_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN_W-2:0], async_in};
    end

    assign rise_o = chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];
endmodule

// File: rtl/lsfm_window.sv
// Module: counts reference cycles since the last slow-clock edge and reports a timeout.
// Assumes the limit is held stable while the monitor is active.
module lsfm_window #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             active_i,
    input  logic             edge_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             fail_o
);
    logic [CNT_W-1:0] cnt_q;

    // Restart on every edge or while idle; otherwise count up to the limit and hold there.
    always_ff @(posedge clk) begin
        if (!por_n || !active_i || edge_i) cnt_q <= '0;
        else if (cnt_q != limit_i)         cnt_q <= cnt_q + 1'b1;
    end

    assign fail_o = active_i && !edge_i && (cnt_q == limit_i);

    // R9
    no_early_fail_chk: assert property (@(posedge clk) disable iff (!por_n)
        edge_i |=> !fail_o || (limit_i == '0));
endmodule

// File: rtl/lsfm_ctrl.sv
// Module: enable bit with its acceptance rule, sticky flag, wake-up request and clock gate.
// Assumes fail_i is a single-cycle detection from the window counter.
module lsfm_ctrl
    import lsfm_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       rtc_swrst,
    input  logic       en_wr,
    input  logic       en_wdata,
    input  logic       xosc_on,
    input  logic       xosc_rdy,
    input  logic       iosc_on,
    input  logic       iosc_rdy,
    input  logic [1:0] rtc_src,
    input  logic [1:0] pmode,
    input  logic       flag_clr,
    input  logic       fail_i,
    output logic       en_o,
    output logic       flag_o,
    output logic       wake_o,
    output logic       pass_o
);
    logic en_q, flag_q, wake_q, pass_q;
    logic set_ok;

    assign set_ok = en_wr && en_wdata && xosc_on && xosc_rdy && iosc_on && iosc_rdy
                    && (rtc_src != 2'd0);

    // Enable bit: set by an accepted write, cleared only by a reset or a failure.
    always_ff @(posedge clk) begin
        if (!por_n || rtc_swrst || fail_i) en_q <= 1'b0;
        else if (set_ok)                   en_q <= 1'b1;
    end

    // Sticky flag: a failure wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!por_n)        flag_q <= 1'b0;
        else if (fail_i)   flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    // Wake request: raised by a failure in low-power mode, dropped on return to run.
    always_ff @(posedge clk) begin
        if (!por_n)                                  wake_q <= 1'b0;
        else if (fail_i && pmode == PM_LOWP)         wake_q <= 1'b1;
        else if (pmode == PM_RUN)                    wake_q <= 1'b0;
    end

    // Clock gate: closes on failure, reopens on power-on or rtc software reset.
    always_ff @(posedge clk) begin
        if (!por_n || rtc_swrst) pass_q <= 1'b1;
        else if (fail_i)         pass_q <= 1'b0;
    end

    assign en_o   = en_q;
    assign flag_o = flag_q;
    assign wake_o = wake_q;
    assign pass_o = pass_q;

    // R1
    en_set_needs_ready_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(en_q) |-> $past(xosc_rdy && iosc_rdy && xosc_on && iosc_on && rtc_src != 2'd0));
    // R2
    en_no_sw_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        en_q && !fail_i && !rtc_swrst |=> en_q);
    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        flag_q && !flag_clr |=> flag_q);
    // R4
    idle_mode_no_fail_chk: assert property (@(posedge clk) disable iff (!por_n)
        (pmode == PM_STBY || pmode == PM_SHDN) |-> !fail_i);
endmodule

// File: rtl/lsclk_fail_mon.sv
// Module: top of the low-speed oscillator failure monitor; also holds the
// system-clock selection, which a failure may override.
// Assumes synchronous active-low resets and a reference clock well above the monitored one.
module lsclk_fail_mon
    import lsfm_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             sys_rst_n,
    input  logic             rtc_swrst,
    input  logic             lsclk_in,
    input  logic             xosc_on,
    input  logic             xosc_rdy,
    input  logic             iosc_on,
    input  logic             iosc_rdy,
    input  logic [1:0]       rtc_src,
    input  logic [1:0]       pmode,
    input  logic             en_wr,
    input  logic             en_wdata,
    input  logic             flag_clr,
    input  logic             sel_wr,
    input  logic [1:0]       sel_wdata,
    input  logic [CNT_W-1:0] win_limit,
    output logic             mon_en,
    output logic             fail_flag,
    output logic             wake_req,
    output logic [1:0]       sysclk_sel,
    output logic             rtc_clk_o
);
    logic ls_rise, fail_det, active, pass;
    logic [1:0] sel_q;

    assign active = mon_en && (pmode == PM_RUN || pmode == PM_LOWP);

    lsfm_edge_sync #(.STAGES(SYNC_STGS)) sync_i (
        .clk(clk), .por_n(por_n), .async_in(lsclk_in), .rise_o(ls_rise)
    );

    lsfm_window #(.CNT_W(CNT_W)) win_i (
        .clk(clk), .por_n(por_n), .active_i(active), .edge_i(ls_rise),
        .limit_i(win_limit), .fail_o(fail_det)
    );

    lsfm_ctrl ctrl_i (
        .clk(clk), .por_n(por_n), .rtc_swrst(rtc_swrst), .en_wr(en_wr),
        .en_wdata(en_wdata), .xosc_on(xosc_on), .xosc_rdy(xosc_rdy),
        .iosc_on(iosc_on), .iosc_rdy(iosc_rdy), .rtc_src(rtc_src), .pmode(pmode),
        .flag_clr(flag_clr), .fail_i(fail_det), .en_o(mon_en), .flag_o(fail_flag),
        .wake_o(wake_req), .pass_o(pass)
    );

    // System-clock selection: system reset defaults it, a failure forces the internal low-speed source.
    always_ff @(posedge clk) begin
        if (!por_n || !sys_rst_n)                 sel_q <= SYS_HSI_INT;
        else if (fail_det && sel_q == SYS_LS_EXT) sel_q <= SYS_LS_INT;
        else if (sel_wr)                          sel_q <= sel_wdata;
    end

    assign sysclk_sel = sel_q;
    assign rtc_clk_o  = lsclk_in & pass;

    // R6
    fail_forces_lsi_chk: assert property (@(posedge clk) disable iff (!por_n)
        fail_det && sel_q == SYS_LS_EXT && sys_rst_n |=> sel_q == SYS_LS_INT);
    // R5
    gate_closed_chk: assert property (@(posedge clk) disable iff (!por_n)
        fail_det && !rtc_swrst |=> !rtc_clk_o);
endmodule

// File: tb/lsclk_fail_mon_tb_top.sv
module lsclk_fail_mon_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 16;
    localparam int LIMIT = 40;

    logic clk = 1'b0;
    logic por_n = 1'b0, sys_rst_n = 1'b1, rtc_swrst = 1'b0, lsclk_in = 1'b0;
    logic xosc_on = 1'b0, xosc_rdy = 1'b0, iosc_on = 1'b0, iosc_rdy = 1'b0;
    logic [1:0] rtc_src = 2'd0, pmode = 2'd0, sel_wdata = 2'd0, sysclk_sel;
    logic en_wr = 1'b0, en_wdata = 1'b0, flag_clr = 1'b0, sel_wr = 1'b0;
    logic [CNT_W-1:0] win_limit = LIMIT[CNT_W-1:0];
    logic mon_en, fail_flag, wake_req, rtc_clk_o;
    logic ls_run = 1'b0;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    lsclk_fail_mon #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .rtc_swrst(rtc_swrst),
        .lsclk_in(lsclk_in), .xosc_on(xosc_on), .xosc_rdy(xosc_rdy), .iosc_on(iosc_on),
        .iosc_rdy(iosc_rdy), .rtc_src(rtc_src), .pmode(pmode), .en_wr(en_wr),
        .en_wdata(en_wdata), .flag_clr(flag_clr), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .win_limit(win_limit), .mon_en(mon_en), .fail_flag(fail_flag),
        .wake_req(wake_req), .sysclk_sel(sysclk_sel), .rtc_clk_o(rtc_clk_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Slow clock: toggles every 8 reference cycles while ls_run is set.
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            if (ls_run) begin
                div = div + 1;
                if (div == 8) begin div = 0; lsclk_in = ~lsclk_in; end
            end
        end
    end

    // {xosc_on, xosc_rdy, iosc_on, iosc_rdy, rtc_src[1:0], wdata, expected mon_en}
    localparam logic [7:0] VEC [8] = '{
        8'b1111_01_1_1, 8'b1111_00_1_0, 8'b0111_01_1_0, 8'b1011_10_1_0,
        8'b1101_11_1_0, 8'b1110_01_1_0, 8'b1111_11_0_0, 8'b1111_10_1_1
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic en_write(input logic v);
        en_wr = 1'b1; en_wdata = v;
        tick(1);
        en_wr = 1'b0; en_wdata = 1'b0;
    endtask

    task automatic sel_write(input logic [1:0] v);
        sel_wr = 1'b1; sel_wdata = v;
        tick(1);
        sel_wr = 1'b0;
    endtask

    task automatic pulse_swrst();
        rtc_swrst = 1'b1; tick(1); rtc_swrst = 1'b0;
    endtask

    // Returns 1 if rtc_clk_o was seen high during n samples.
    task automatic watch_rtc(input int n, output logic seen);
        seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            tick(1);
            seen = seen | rtc_clk_o;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic seen;
        tick(5);
        // R3: the reset state after power-on reset
        check("R3 reset mon_en", mon_en, 0);
        check("R3 reset fail_flag", fail_flag, 0);
        check("R3 reset wake_req", wake_req, 0);
        check("R3 reset sysclk_sel", sysclk_sel, 0);
        por_n = 1'b1;
        ls_run = 1'b1;
        tick(2);

        // R1: acceptance table
        for (int k = 0; k < 8; k++) begin
            pulse_swrst();
            {xosc_on, xosc_rdy, iosc_on, iosc_rdy, rtc_src} = VEC[k][7:2];
            tick(1);
            en_write(VEC[k][1]);
            check($sformatf("R1 vector %0d mon_en", k), mon_en, VEC[k][0]);
        end

        // R2: a zero write cannot clear the enable
        en_write(1'b0);
        check("R2 zero write keeps mon_en", mon_en, 1);

        // R9 and R5: a healthy clock never trips, and the gate passes it
        watch_rtc(200, seen);
        check("R9 healthy clock no fail", fail_flag, 0);
        check("R5 rtc clock passes", seen, 1);

        // R3: a system reset defaults the selection and keeps the monitor
        sel_write(2'd3);
        check("R6 selection written", sysclk_sel, 3);
        sys_rst_n = 1'b0; tick(2); sys_rst_n = 1'b1;
        check("R3 sysrst selection default", sysclk_sel, 0);
        check("R3 sysrst keeps mon_en", mon_en, 1);
        sel_write(2'd3);

        // R4: standby and shutdown never detect
        pmode = 2'd2; ls_run = 1'b0; tick(100);
        check("R4 standby no fail", fail_flag, 0);
        pmode = 2'd3; tick(100);
        check("R4 shutdown no fail", fail_flag, 0);
        check("R4 mon_en kept", mon_en, 1);

        // R9: stopped for less than the window
        pmode = 2'd0; tick(20);
        check("R9 short gap no fail", fail_flag, 0);
        tick(40);
        check("R9 long gap fails", fail_flag, 1);
        check("R2 failure clears mon_en", mon_en, 0);
        check("R6 forced to internal low-speed", sysclk_sel, 2);
        check("R7 no wake in run", wake_req, 0);
        ls_run = 1'b1;
        watch_rtc(40, seen);
        check("R5 gate closed after failure", seen, 0);

        // R8: the flag is sticky until cleared
        check("R8 flag still set", fail_flag, 1);
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
        check("R8 flag cleared", fail_flag, 0);

        // R5 and R2: the rtc software reset reopens the gate
        pulse_swrst();
        watch_rtc(40, seen);
        check("R5 gate reopened", seen, 1);

        // R7 and R6: a failure in low-power mode with a non-low-speed selection
        en_write(1'b1);
        check("R1 re-enable", mon_en, 1);
        sel_write(2'd1);
        pmode = 2'd1; ls_run = 1'b0; tick(70);
        check("R7 fail flag in low-power", fail_flag, 1);
        check("R7 wake request", wake_req, 1);
        check("R6 selection untouched", sysclk_sel, 1);
        pmode = 2'd0; tick(2);
        check("R7 wake dropped in run", wake_req, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule